// File: doc/BRIEF.md
# Secure access remap unit

This bus slave lets software reach chosen peripheral registers whose ordinary address range is blocked by the protection logic. Software first loads one of a bank of remap target registers with the address of the register it needs. It then arms that channel by writing the unlock register. The next read or write to the channel's window is carried out on a bus master port at the stored target address. Read data and error responses come back through the slave port in the same transaction.

Remap targets are checked against the top-of-memory window 0xFFFC0000 to 0xFFFFFFFF when they are written. A value outside that window is refused. An arm lasts for exactly one channel access and lapses after a fixed number of clock cycles. Three sticky status bits record refused targets, errors on the master side and accesses to channels that are not armed. Any status bit whose mask bit is set raises the interrupt line.

The slave port uses a request and acknowledge handshake. The requester holds `s_req` and the request fields steady until it sees `s_ack` high for one cycle. The master port works the same way in the other direction. `m_req` stays high until the target pulses `m_ack` or `m_err`. Only one forwarded access is in flight at any time.

Top module: `sau_remap_top`

## Requirements
- R1: After reset, `s_ack`, `m_req` and `irq` are low. The status register (word 1) and the mask register (word 4) both read 0.
- R2: Remap register n sits at slave word 0x40+n and reads 0xFFFC0000 after reset. A write with bits 31:18 all ones is stored and reads back unchanged.
- R3: A remap write whose bits 31:18 are not all ones leaves the stored value unchanged. It still gets an acknowledge without error, and it sets status bit 0.
- R4: A write to word 0 with 0xA5 in bits 31:24 and channel n in bits 5:0 arms channel n. The next access to channel window word 0x80+n is then forwarded on the master port to the stored target, with the same direction and write data. The read data from the master port is returned unchanged, with `s_err` low.
- R5: A channel-window access that is not armed gets `s_ack` with `s_err` high and sets status bit 2, and nothing appears on the master port. This covers no arm, an arm with a wrong key, an arm for another channel, and an arm already used up. Any channel access uses up the arm.
- R6: An arm is honoured only if the channel request is sampled no more than UNLOCK_CYCLES (default 255) clock edges after the unlock request was sampled. Any later request is treated as locked.
- R7: An `m_err` response to a forwarded access gives `s_err` high and read data 0 on the slave port, and sets status bit 1.
- R8: `m_req`, `m_addr` and `m_we` hold steady until `m_ack` or `m_err`. `s_ack` is never high while `m_req` is high.
- R9: Writing word 2 sets every mask bit that has a 1 in the data. Writing word 3 clears every mask bit that has a 1 in the data. Zero data bits leave the mask unchanged.
- R10: `irq` is high while any status bit and its mask bit are both set. Writing word 5 clears the status bits that have a 1 in the data, and zero data bits leave them set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req | input | 1 | Slave request, held until acknowledged |
| s_we | input | 1 | Slave write (1) or read (0) |
| s_addr | input | 8 | Slave word address |
| s_wdata | input | 32 | Slave write data |
| s_ack | output | 1 | One-cycle slave acknowledge |
| s_err | output | 1 | Slave error, valid with s_ack |
| s_rdata | output | 32 | Slave read data, valid with s_ack |
| m_req | output | 1 | Master request, held until answered |
| m_we | output | 1 | Master write (1) or read (0) |
| m_addr | output | 32 | Master byte address (the remap target) |
| m_wdata | output | 32 | Master write data |
| m_ack | input | 1 | Master transfer done |
| m_err | input | 1 | Master transfer failed |
| m_rdata | input | 32 | Master read data, valid with m_ack |
| irq | output | 1 | Interrupt request |

## Verification
The arm timer running out and a channel request arriving can fall on the same clock edge. Which one wins decides whether the access goes through or is refused. The bench arms a channel, waits a precisely counted number of cycles and then issues the access. In one run the request is sampled on the last edge that still counts, and the access must be forwarded with the expected read data. In the other run it is sampled one edge later, and the access must come back locked with status bit 2 set and no new master transfer.

// File: rtl/sau_pkg.sv
package sau_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DECIDE, ST_MREQ, ST_ACK} sau_state_e;

  localparam int STAT_W      = 3;
  localparam int ST_ADDR_ERR = 0;
  localparam int ST_MBUS_ERR = 1;
  localparam int ST_LOCK_ERR = 2;

  // leading address bits that must be ones for a legal remap target
  localparam int WIN_BITS = 14;

  localparam logic [2:0] REG_UNLOCK = 3'd0;
  localparam logic [2:0] REG_STATUS = 3'd1;
  localparam logic [2:0] REG_IEN    = 3'd2;
  localparam logic [2:0] REG_IDIS   = 3'd3;
  localparam logic [2:0] REG_MASK   = 3'd4;
  localparam logic [2:0] REG_ICLR   = 3'd5;
endpackage

// File: rtl/sau_remap_bank.sv
module sau_remap_bank
  import sau_pkg::*;
#(
  parameter int NCH   = 63,
  parameter int AW    = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [AW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [AW-1:0]    rd_data,
  output logic             wr_reject
);
  localparam int OFF_W = AW - WIN_BITS;
  localparam int DEPTH = 2 ** IDX_W;

  // only the offset inside the window is stored; no reset, so RAM can be inferred
  logic [OFF_W-1:0] off_mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [OFF_W-1:0] rd_off;
  logic             rd_vld;
  logic             idx_ok;
  logic             in_win;

  assign idx_ok    = wr_idx < IDX_W'(NCH);
  assign in_win    = &wr_data[AW-1:OFF_W];
  assign wr_reject = wr_en && idx_ok && !in_win;

  always_ff @(posedge clk) begin
    if (wr_en && idx_ok && in_win) off_mem[wr_idx] <= wr_data[OFF_W-1:0];
    rd_off <= off_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en && idx_ok && in_win) vld[wr_idx] <= 1'b1;
      rd_vld <= vld[rd_idx];
    end
  end

  assign rd_data = {{WIN_BITS{1'b1}}, (rd_vld ? rd_off : {OFF_W{1'b0}})};

  // R3
  reject_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    wr_reject |=> vld[$past(wr_idx)] == $past(vld[wr_idx]));
endmodule

// File: rtl/sau_unlock.sv
module sau_unlock #(
  parameter int          IDX_W = 6,
  parameter int          TMO   = 255,
  parameter logic [7:0]  KEY   = 8'hA5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [7:0]       key_in,
  input  logic [IDX_W-1:0] ch_in,
  input  logic             check,
  input  logic [IDX_W-1:0] ch,
  output logic             grant
);
  localparam int CNT_W = $clog2(TMO + 1);

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] armed_ch;

  assign grant = check && (cnt != '0) && (ch == armed_ch);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      armed_ch <= '0;
    end else if (load && key_in == KEY) begin
      cnt      <= CNT_W'(TMO);
      armed_ch <= ch_in;
    end else if (check) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R5
  arm_used_chk: assert property (@(posedge clk) disable iff (rst)
    (check && !load) |=> cnt == '0);
  // R6
  arm_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= TMO);
endmodule

// File: rtl/sau_irq.sv
module sau_irq #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] set_vec,
  input  logic          ien_we,
  input  logic          idis_we,
  input  logic          iclr_we,
  input  logic [SW-1:0] wbits,
  output logic [SW-1:0] sr,
  output logic [SW-1:0] imr,
  output logic          irq
);
  logic [SW-1:0] sr_n;
  logic [SW-1:0] imr_n;

  always_comb begin
    sr_n  = (sr & ~(iclr_we ? wbits : '0)) | set_vec;
    imr_n = (imr | (ien_we ? wbits : '0)) & ~(idis_we ? wbits : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      imr <= '0;
      irq <= 1'b0;
    end else begin
      sr  <= sr_n;
      imr <= imr_n;
      irq <= |(sr_n & imr_n);
    end
  end

  // R10
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (iclr_we && set_vec == '0) |=> (sr & $past(wbits)) == '0);
  // R9
  enable_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (ien_we && !idis_we) |=> (imr & $past(wbits)) == $past(wbits));
  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (sr & imr) != '0);
endmodule

// File: rtl/sau_remap_top.sv
module sau_remap_top
  import sau_pkg::*;
#(
  parameter int         NCH           = 63,
  parameter int         AW            = 32,
  parameter int         DW            = 32,
  parameter int         UNLOCK_CYCLES = 255,
  parameter logic [7:0] KEY           = 8'hA5,
  localparam int        IDX_W         = $clog2(NCH + 1),
  localparam int        SA_W          = IDX_W + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s_req,
  input  logic            s_we,
  input  logic [SA_W-1:0] s_addr,
  input  logic [DW-1:0]   s_wdata,
  output logic            s_ack,
  output logic            s_err,
  output logic [DW-1:0]   s_rdata,
  output logic            m_req,
  output logic            m_we,
  output logic [AW-1:0]   m_addr,
  output logic [DW-1:0]   m_wdata,
  input  logic            m_ack,
  input  logic            m_err,
  input  logic [DW-1:0]   m_rdata,
  output logic            irq
);
  sau_state_e        state;
  logic              r_we;
  logic [SA_W-1:0]   r_addr;
  logic [DW-1:0]     r_wdata;

  logic              decide, is_ch, is_map, is_ctl;
  logic [2:0]        sel;
  logic [IDX_W-1:0]  idx;
  logic              grant, grant_ok;
  logic [AW-1:0]     map_rd;
  logic              wr_reject;
  logic [STAT_W-1:0] sr, imr, set_vec;
  logic [DW-1:0]     rd_mux;

  assign decide = state == ST_DECIDE;
  assign is_ch  = r_addr[SA_W-1];
  assign is_map = r_addr[SA_W-1:SA_W-2] == 2'b01;
  assign is_ctl = r_addr[SA_W-1:SA_W-2] == 2'b00;
  assign sel    = r_addr[2:0];
  assign idx    = r_addr[IDX_W-1:0];
  assign grant_ok = grant && (idx < IDX_W'(NCH));

  sau_remap_bank #(.NCH(NCH), .AW(AW), .IDX_W(IDX_W)) i_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (decide && is_map && r_we),
    .wr_idx   (idx),
    .wr_data  (r_wdata[AW-1:0]),
    .rd_idx   (s_addr[IDX_W-1:0]),
    .rd_data  (map_rd),
    .wr_reject(wr_reject)
  );

  sau_unlock #(.IDX_W(IDX_W), .TMO(UNLOCK_CYCLES), .KEY(KEY)) i_unlock (
    .clk   (clk),
    .rst   (rst),
    .load  (decide && is_ctl && r_we && sel == REG_UNLOCK),
    .key_in(r_wdata[DW-1:DW-8]),
    .ch_in (r_wdata[IDX_W-1:0]),
    .check (decide && is_ch),
    .ch    (idx),
    .grant (grant)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[ST_ADDR_ERR] = wr_reject;
    set_vec[ST_MBUS_ERR] = (state == ST_MREQ) && m_err;
    set_vec[ST_LOCK_ERR] = decide && is_ch && !grant_ok;
  end

  sau_irq #(.SW(STAT_W)) i_irq (
    .clk    (clk),
    .rst    (rst),
    .set_vec(set_vec),
    .ien_we (decide && is_ctl && r_we && sel == REG_IEN),
    .idis_we(decide && is_ctl && r_we && sel == REG_IDIS),
    .iclr_we(decide && is_ctl && r_we && sel == REG_ICLR),
    .wbits  (r_wdata[STAT_W-1:0]),
    .sr     (sr),
    .imr    (imr),
    .irq    (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (is_map) rd_mux = DW'(map_rd);
    else if (is_ctl && sel == REG_STATUS) rd_mux = DW'(sr);
    else if (is_ctl && sel == REG_MASK)   rd_mux = DW'(imr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      r_we    <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      s_ack   <= 1'b0;
      s_err   <= 1'b0;
      s_rdata <= '0;
      m_req   <= 1'b0;
      m_we    <= 1'b0;
      m_addr  <= '0;
      m_wdata <= '0;
    end else begin
      s_ack <= 1'b0;
      case (state)
        ST_IDLE: if (s_req) begin
          r_we    <= s_we;
          r_addr  <= s_addr;
          r_wdata <= s_wdata;
          state   <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (is_ch && grant_ok) begin
            m_req   <= 1'b1;
            m_we    <= r_we;
            m_addr  <= map_rd;
            m_wdata <= r_wdata;
            state   <= ST_MREQ;
          end else begin
            s_err   <= is_ch;
            s_rdata <= (r_we || is_ch) ? '0 : rd_mux;
            s_ack   <= 1'b1;
            state   <= ST_ACK;
          end
        end
        ST_MREQ: if (m_ack || m_err) begin
          m_req   <= 1'b0;
          s_err   <= m_err;
          s_rdata <= (m_err || m_we) ? '0 : m_rdata;
          s_ack   <= 1'b1;
          state   <= ST_ACK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  mreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ack && !m_err) |=> m_req && $stable(m_addr) && $stable(m_we));
  // R8
  ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    m_req |-> !s_ack);
  // R5
  lock_noforward_chk: assert property (@(posedge clk) disable iff (rst)
    (decide && is_ch && !grant_ok) |=> s_ack && s_err && !m_req);
  // R7
  mbus_err_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_err) |=> s_ack && s_err && sr[ST_MBUS_ERR]);
endmodule

// File: tb/test_sau_remap_top.sv
module test_sau_remap_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 255;
  localparam int LAT        = 2;
  localparam logic [31:0] BAD_ADDR = 32'hFFFF_FFF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_req = 1'b0, s_we = 1'b0;
  logic [7:0]  s_addr = '0;
  logic [31:0] s_wdata = '0;
  logic        s_ack, s_err;
  logic [31:0] s_rdata;
  logic        m_req, m_we;
  logic [31:0] m_addr, m_wdata;
  logic        m_ack = 1'b0, m_err = 1'b0;
  logic [31:0] m_rdata = '0;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  sau_remap_top i_sau_remap_top (
    .clk(clk), .rst(rst), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
    .s_wdata(s_wdata), .s_ack(s_ack), .s_err(s_err), .s_rdata(s_rdata),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata), .irq(irq)
  );

  typedef struct {
    logic [31:0] rdata;
    logic        err;
    logic        chk_rd;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          total = 0, bad = 0;
  int          fwd_cnt = 0, hold_bad = 0, wait_cnt = 0;
  logic [31:0] held_addr = '0, last_addr = '0, last_wdata = '0;
  logic        last_we = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [7:0] addr, input logic [31:0] wd,
                      input logic [31:0] exp_rd, input logic exp_err, input logic chk_rd,
                      input string tag);
    exp_t e;
    e.rdata = exp_rd; e.err = exp_err; e.chk_rd = chk_rd; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    s_req = 1'b1; s_we = we; s_addr = addr; s_wdata = wd;
    do @(negedge clk); while (!s_ack);
    s_req = 1'b0;
  endtask

  // monitor: pop expected items as the design acknowledges
  initial forever begin
    @(negedge clk);
    if (s_ack) begin
      if (sb.size() == 0) check("scoreboard empty", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " err"}, {31'd0, s_err}, {31'd0, e.err});
        if (e.chk_rd) check({e.tag, " rdata"}, s_rdata, e.rdata);
      end
    end
  end

  // master side target model, R8 watcher
  initial forever begin
    @(negedge clk);
    if (m_req && s_ack) hold_bad++;
    if (m_ack || m_err) begin
      m_ack = 1'b0; m_err = 1'b0;
    end else if (m_req) begin
      if (wait_cnt == 0) held_addr = m_addr;
      else if (m_addr !== held_addr) hold_bad++;
      if (wait_cnt == LAT) begin
        if (m_addr == BAD_ADDR) begin m_err = 1'b1; m_rdata = 32'h1234_5678; end
        else begin m_ack = 1'b1; m_rdata = ~m_addr; end
        fwd_cnt++; last_addr = m_addr; last_we = m_we; last_wdata = m_wdata;
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [7:0] A_UNL = 8'h00, A_ST = 8'h01, A_IEN = 8'h02, A_IDIS = 8'h03,
                         A_MASK = 8'h04, A_ICLR = 8'h05;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset outputs and registers
    check("R1 s_ack", {31'd0, s_ack}, 32'd0);
    check("R1 m_req", {31'd0, m_req}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    xfer(0, A_ST, 0, 32'd0, 0, 1, "R1 status");
    xfer(0, A_MASK, 0, 32'd0, 0, 1, "R1 mask");
    // R2 remap reset value, store and read back
    xfer(0, 8'h43, 0, 32'hFFFC_0000, 0, 1, "R2 reset target");
    xfer(1, 8'h43, 32'hFFFC_1230, 0, 0, 0, "R2 write");
    xfer(0, 8'h43, 0, 32'hFFFC_1230, 0, 1, "R2 readback");
    // R3 out-of-window target refused
    xfer(1, 8'h43, 32'h4000_1000, 0, 0, 0, "R3 bad write");
    xfer(0, 8'h43, 0, 32'hFFFC_1230, 0, 1, "R3 kept");
    xfer(0, A_ST, 0, 32'd1, 0, 1, "R3 status");
    // R9 / R10 mask and irq
    xfer(1, A_IEN, 32'd7, 0, 0, 0, "R9 ien");
    xfer(0, A_MASK, 0, 32'd7, 0, 1, "R9 mask set");
    check("R10 irq on", {31'd0, irq}, 32'd1);
    xfer(1, A_IDIS, 32'd1, 0, 0, 0, "R9 idis");
    xfer(0, A_MASK, 0, 32'd6, 0, 1, "R9 mask clr");
    check("R10 irq masked", {31'd0, irq}, 32'd0);
    xfer(1, A_IEN, 32'd0, 0, 0, 0, "R9 ien zero");
    xfer(1, A_IDIS, 32'd0, 0, 0, 0, "R9 idis zero");
    xfer(0, A_MASK, 0, 32'd6, 0, 1, "R9 zeros no effect");
    xfer(1, A_ICLR, 32'd0, 0, 0, 0, "R10 iclr zero");
    xfer(0, A_ST, 0, 32'd1, 0, 1, "R10 zero keeps");
    xfer(1, A_ICLR, 32'd1, 0, 0, 0, "R10 iclr");
    xfer(0, A_ST, 0, 32'd0, 0, 1, "R10 cleared");
    // R5 not armed
    xfer(0, 8'h83, 0, 32'd0, 1, 0, "R5 no arm");
    check("R5 no forward", fwd_cnt, 0);
    xfer(0, A_ST, 0, 32'd4, 0, 1, "R5 status");
    check("R10 irq lock", {31'd0, irq}, 32'd1);
    xfer(1, A_ICLR, 32'd7, 0, 0, 0, "clr");
    check("R10 irq off", {31'd0, irq}, 32'd0);
    xfer(1, A_UNL, 32'h5A00_0003, 0, 0, 0, "R5 wrong key");
    xfer(0, 8'h83, 0, 32'd0, 1, 0, "R5 wrong key access");
    check("R5 wrong key no forward", fwd_cnt, 0);
    // R4 armed read, then arm used up
    xfer(1, A_UNL, 32'hA500_0003, 0, 0, 0, "R4 arm");
    xfer(0, 8'h83, 0, 32'h0003_EDCF, 0, 1, "R4 fwd read");
    check("R4 fwd count", fwd_cnt, 1);
    check("R4 fwd addr", last_addr, 32'hFFFC_1230);
    check("R4 fwd dir", {31'd0, last_we}, 32'd0);
    xfer(0, 8'h83, 0, 32'd0, 1, 0, "R5 used arm");
    check("R5 used no forward", fwd_cnt, 1);
    xfer(1, A_UNL, 32'hA500_0003, 0, 0, 0, "R4 arm2");
    xfer(1, 8'h83, 32'hDEAD_BEEF, 0, 0, 0, "R4 fwd write");
    check("R4 write dir", {31'd0, last_we}, 32'd1);
    check("R4 write data", last_wdata, 32'hDEAD_BEEF);
    xfer(1, A_UNL, 32'hA500_0005, 0, 0, 0, "R5 arm other");
    xfer(0, 8'h83, 0, 32'd0, 1, 0, "R5 other channel");
    check("R5 other no forward", fwd_cnt, 2);
    xfer(1, A_ICLR, 32'd7, 0, 0, 0, "clr");
    // R6 arm lifetime boundary
    xfer(1, A_UNL, 32'hA500_0003, 0, 0, 0, "R6 arm");
    repeat (TMO - 3) @(negedge clk);
    xfer(0, 8'h83, 0, 32'h0003_EDCF, 0, 1, "R6 last edge");
    check("R6 last edge forwarded", fwd_cnt, 3);
    xfer(1, A_UNL, 32'hA500_0003, 0, 0, 0, "R6 arm late");
    repeat (TMO - 2) @(negedge clk);
    xfer(0, 8'h83, 0, 32'd0, 1, 0, "R6 expired");
    check("R6 expired no forward", fwd_cnt, 3);
    xfer(0, A_ST, 0, 32'd4, 0, 1, "R6 status");
    xfer(1, A_ICLR, 32'd7, 0, 0, 0, "clr");
    // R7 master error
    xfer(1, 8'h47, BAD_ADDR, 0, 0, 0, "R7 target");
    xfer(1, A_UNL, 32'hA500_0007, 0, 0, 0, "R7 arm");
    xfer(0, 8'h87, 0, 32'd0, 1, 1, "R7 error access");
    check("R7 forwarded", fwd_cnt, 4);
    xfer(0, A_ST, 0, 32'd2, 0, 1, "R7 status");
    check("R7 irq", {31'd0, irq}, 32'd1);
    // R8 hold and exclusivity over all forwarded accesses
    check("R8 hold", hold_bad, 0);
    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule